// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twelve interrupt sources and presents the processor core with one request strobe and a 16-bit vector address. The sources are a boot request, a power-down request, six active-low external lines, transmit and receive requests from two serial ports, a byte-DMA request and a timer request. Every source has a fixed priority rank, from 0 (highest) to 11 (lowest). Ranks 0 and 1 cannot be masked. Ranks 2 to 11 are each gated by a bit of the mask register.

Edge-type requests are held in pending latches. Level-type requests follow their synchronized line. The controller ANDs the pending requests with the mask and offers the highest-ranked survivor. The core then takes it with `irq_ack` and later releases it with `irq_rti`.

A small state machine tracks whether anything is in service:
- `ST_IDLE`: nothing is in service. It moves to `ST_SERVE` on a *take*, which is an acknowledge while a request is offered.
- `ST_SERVE`: one or more ranks are in service. It moves back to `ST_IDLE` on the *last release*, which is a return pulse that empties the in-service set with no take in the same cycle.

Further behaviour:
- A control register chooses, per selectable line, between edge and level sensing. It also chooses nested or sequential servicing.
- The same control register can hand the second serial port's two vectors over to two external lines.
- A write-only force/clear register sets or clears the pending latches.
- Any write to the mask register blanks every maskable source for the following cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Rank order and vectors:
  - rank 0 boot (0x0000), rank 1 power-down (0x002C), rank 2 line 0 (0x0004), rank 3 line 1 (0x0008), rank 4 line 2 (0x000C);
  - rank 5 port-0 transmit (0x0010), rank 6 port-0 receive (0x0014), rank 7 line 3 (0x0018), rank 8 byte DMA (0x001C);
  - rank 9 port-1 transmit or line 4 (0x0020), rank 10 port-1 receive or line 5 (0x0024), rank 11 timer (0x0028).
  - When several sources are eligible, the lowest rank is offered on `irq_vec` with `irq_req` high. With no offer, `irq_vec` is 0.
- R2: Mask bit k gates rank k+2, and a cleared bit suppresses that source. Ranks 0 and 1 are never masked. The mask resets to all zeros.
- R3: In the cycle after any `mask_we`, every maskable rank is suppressed. Ranks 0 and 1 are still offered in that cycle.
- R4: Control bit 0 (line 0), bit 1 (line 4) and bit 2 (line 5) select edge sensing when set. External lines pass through a two-stage synchronizer:
  - A level request is visible after two clock edges.
  - An edge request latches on a high-to-low transition and is visible one edge later. It stays pending after the line returns high.
- R5: Lines 1 and 2 are always level-sensitive. Line 3 is always edge-sensitive.
- R6: A `fc_we` write sets the pending latch of rank k+2 for each set bit k in [9:0]. It clears that latch for each set bit 10+k in [19:10].
- R7: A take clears the pending latch of the offered rank and marks that rank in service.
- R8: Control bit 3 set selects nested mode. A request is offered only when its rank is numerically below every rank in service. Each `irq_rti` releases the highest-priority rank in service.
- R9: With control bit 3 clear (sequential mode), nothing is offered while any rank is in service.
- R10: Control bit 4 selects the pin roles for ranks 9 and 10. When set, ranks 9 and 10 take lines 4 and 5 and ignore the port-1 requests. When clear, they take the port-1 requests and ignore lines 4 and 5.
- R11: After reset the block is in `ST_IDLE` with no request offered, the mask is zero and the control register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 6 | Active-low external lines 0..5 |
| boot_req | input | 1 | Rank 0 request |
| pdn_req | input | 1 | Rank 1 power-down request |
| sp0_tx_req | input | 1 | Port-0 transmit request |
| sp0_rx_req | input | 1 | Port-0 receive request |
| dma_req | input | 1 | Byte-DMA request |
| sp1_tx_req | input | 1 | Port-1 transmit request |
| sp1_rx_req | input | 1 | Port-1 receive request |
| tmr_req | input | 1 | Timer request |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 10 | New mask value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | New control value |
| fc_we | input | 1 | Force/clear write strobe |
| fc_wdata | input | 20 | Force bits [9:0], clear bits [19:10] |
| irq_ack | input | 1 | Core takes the offered request |
| irq_rti | input | 1 | Core returns from a routine |
| irq_req | output | 1 | Request strobe to the core |
| irq_vec | output | 16 | Vector address of the offered rank |

## Verification
The hardest situation to reach from the ports is a stack of nested ranks in service that must be unwound in priority order while further pending latches wait behind them. The stimulus forces a low rank and takes it, then forces a higher rank and takes it, then forces the low rank again. It then issues return pulses one at a time and checks that the re-forced low rank appears only once its own level has been released. A long randomized phase then mixes mask and control writes, forced latches, line edges and random acknowledges and returns. In that phase a behavioural model is compared against the outputs on every cycle.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
    localparam int NSRC  = 12;
    localparam int NMASK = NSRC - 2;
    localparam int NLINE = 6;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = 16;
    localparam int CTL_W = 5;
    localparam int FC_W  = 2 * NMASK;

    localparam int CTL_EDGE_L0 = 0;
    localparam int CTL_EDGE_L4 = 1;
    localparam int CTL_EDGE_L5 = 2;
    localparam int CTL_NEST    = 3;
    localparam int CTL_ALT     = 4;

    localparam int RK_BOOT = 0;
    localparam int RK_PDN  = 1;
    localparam int RK_L0   = 2;
    localparam int RK_L1   = 3;
    localparam int RK_L2   = 4;
    localparam int RK_S0T  = 5;
    localparam int RK_S0R  = 6;
    localparam int RK_L3   = 7;
    localparam int RK_DMA  = 8;
    localparam int RK_S1T  = 9;
    localparam int RK_S1R  = 10;
    localparam int RK_TMR  = 11;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } svc_state_e;

    function automatic logic [VEC_W-1:0] rank_vector(input logic [IDX_W-1:0] r);
        logic [VEC_W-1:0] v;
        v = '0;
        if (r == IDX_W'(RK_PDN)) begin
            v = VEC_W'(16'h002C);
        end else if (r != IDX_W'(RK_BOOT)) begin
            v[IDX_W+1:2] = r - IDX_W'(1);
        end
        return v;
    endfunction
endpackage

// File: rtl/ivc_line_sync.sv
module ivc_line_sync #(
    parameter int NLINES = 6,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_n,
    output logic [NLINES-1:0] lvl_o,
    output logic [NLINES-1:0] fall_o
);
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], line_n[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl_o[g]  = ~chain_q[STAGES-1];
        assign fall_o[g] = prev_q & ~chain_q[STAGES-1];

        AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            fall_o[g] |=> !fall_o[g]); // R4
    end
endmodule

// File: rtl/ivc_pend.sv
module ivc_pend
    import irq_vector_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] lvl_i,
    input  logic [NLINE-1:0] fall_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic             boot_i,
    input  logic             pdn_i,
    input  logic             s0t_i,
    input  logic             s0r_i,
    input  logic             dma_i,
    input  logic             s1t_i,
    input  logic             s1r_i,
    input  logic             tmr_i,
    input  logic             fc_we_i,
    input  logic [FC_W-1:0]  fc_data_i,
    input  logic             take_i,
    input  logic [IDX_W-1:0] take_rank_i,
    output logic [NSRC-1:0]  req_o
);
    logic [NSRC-1:0] has_line;
    logic [NSRC-1:0] line_lvl;
    logic [NSRC-1:0] line_fall;
    logic [NSRC-1:0] edge_sel;
    logic [NSRC-1:0] side_req;

    // route lines and peripheral requests onto ranks
    always_comb begin
        has_line  = '0;
        line_lvl  = '0;
        line_fall = '0;
        edge_sel  = '0;
        side_req  = '0;
        side_req[RK_BOOT] = boot_i;
        side_req[RK_PDN]  = pdn_i;
        has_line[RK_L0]   = 1'b1;
        line_lvl[RK_L0]   = lvl_i[0];
        line_fall[RK_L0]  = fall_i[0];
        edge_sel[RK_L0]   = ctl_i[CTL_EDGE_L0];
        has_line[RK_L1]   = 1'b1;
        line_lvl[RK_L1]   = lvl_i[1];
        line_fall[RK_L1]  = fall_i[1];
        has_line[RK_L2]   = 1'b1;
        line_lvl[RK_L2]   = lvl_i[2];
        line_fall[RK_L2]  = fall_i[2];
        side_req[RK_S0T]  = s0t_i;
        side_req[RK_S0R]  = s0r_i;
        has_line[RK_L3]   = 1'b1;
        line_lvl[RK_L3]   = lvl_i[3];
        line_fall[RK_L3]  = fall_i[3];
        edge_sel[RK_L3]   = 1'b1;
        side_req[RK_DMA]  = dma_i;
        if (ctl_i[CTL_ALT]) begin
            has_line[RK_S1T]  = 1'b1;
            line_lvl[RK_S1T]  = lvl_i[4];
            line_fall[RK_S1T] = fall_i[4];
            edge_sel[RK_S1T]  = ctl_i[CTL_EDGE_L4];
            has_line[RK_S1R]  = 1'b1;
            line_lvl[RK_S1R]  = lvl_i[5];
            line_fall[RK_S1R] = fall_i[5];
            edge_sel[RK_S1R]  = ctl_i[CTL_EDGE_L5];
        end else begin
            side_req[RK_S1T]  = s1t_i;
            side_req[RK_S1R]  = s1r_i;
        end
        side_req[RK_TMR] = tmr_i;
    end

    for (genvar r = 0; r < NSRC; r++) begin : g_rank
        if (r < 2) begin : g_fixed
            // non-maskable ranks are plain levels, no latch
            assign req_o[r] = side_req[r] | (has_line[r] &
                ((~edge_sel[r] & line_lvl[r]) | (edge_sel[r] & line_fall[r])));
        end else begin : g_latch
            logic pend_q;
            logic set_w;
            logic clr_w;

            assign set_w = (fc_we_i & fc_data_i[r-2])
                         | (has_line[r] & edge_sel[r] & line_fall[r]);
            assign clr_w = (fc_we_i & fc_data_i[NMASK+r-2])
                         | (take_i & (take_rank_i == IDX_W'(r)));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= (pend_q & ~clr_w) | set_w;
                end
            end

            assign req_o[r] = pend_q | side_req[r]
                            | (has_line[r] & ~edge_sel[r] & line_lvl[r]);

            AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (fc_we_i && fc_data_i[r-2]) |=> req_o[r]); // R6
        end
    end

    AST_EDGE_LINE3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i[3] |=> req_o[RK_L3]); // R5
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio
    import irq_vector_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req_i,
    input  logic [NMASK-1:0] mask_i,
    input  logic             blk_i,
    input  logic [NSRC-1:0]  isr_i,
    input  logic             nest_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] rank_o,
    output logic [VEC_W-1:0] vec_o
);
    logic [NSRC-1:0]  elig;
    logic             found;
    logic [IDX_W-1:0] cand;
    logic             busy;
    logic [IDX_W-1:0] top_svc;

    assign elig = req_i & {mask_i & {NMASK{~blk_i}}, 2'b11};

    always_comb begin
        found = 1'b0;
        cand  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                cand  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        busy    = 1'b0;
        top_svc = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (isr_i[i]) begin
                busy    = 1'b1;
                top_svc = IDX_W'(i);
            end
        end
    end

    assign hit_o  = found & (~busy | (nest_i & (cand < top_svc)));
    assign rank_o = cand;
    assign vec_o  = rank_vector(cand);

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && rank_o >= IDX_W'(2)) |-> (mask_i[rank_o - IDX_W'(2)] && !blk_i)); // R2
    AST_HIT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> req_i[rank_o]); // R1
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       ext_n,
    input  logic             boot_req,
    input  logic             pdn_req,
    input  logic             sp0_tx_req,
    input  logic             sp0_rx_req,
    input  logic             dma_req,
    input  logic             sp1_tx_req,
    input  logic             sp1_rx_req,
    input  logic             tmr_req,
    input  logic             mask_we,
    input  logic [9:0]       mask_wdata,
    input  logic             ctl_we,
    input  logic [4:0]       ctl_wdata,
    input  logic             fc_we,
    input  logic [19:0]      fc_wdata,
    input  logic             irq_ack,
    input  logic             irq_rti,
    output logic             irq_req,
    output logic [15:0]      irq_vec
);
    logic [NMASK-1:0] mask_q;
    logic [CTL_W-1:0] ctl_q;
    logic             blk_q;
    logic [NSRC-1:0]  isr_q;
    logic [NSRC-1:0]  isr_d;
    svc_state_e       state_q;
    svc_state_e       state_d;

    logic [NLINE-1:0] lvl_w;
    logic [NLINE-1:0] fall_w;
    logic [NSRC-1:0]  req_w;
    logic             hit_w;
    logic [IDX_W-1:0] rank_w;
    logic [VEC_W-1:0] vec_w;
    logic             take_w;

    ivc_line_sync #(.NLINES(NLINE), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (ext_n),
        .lvl_o  (lvl_w),
        .fall_o (fall_w)
    );

    ivc_pend u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_i       (lvl_w),
        .fall_i      (fall_w),
        .ctl_i       (ctl_q),
        .boot_i      (boot_req),
        .pdn_i       (pdn_req),
        .s0t_i       (sp0_tx_req),
        .s0r_i       (sp0_rx_req),
        .dma_i       (dma_req),
        .s1t_i       (sp1_tx_req),
        .s1r_i       (sp1_rx_req),
        .tmr_i       (tmr_req),
        .fc_we_i     (fc_we),
        .fc_data_i   (fc_wdata),
        .take_i      (take_w),
        .take_rank_i (rank_w),
        .req_o       (req_w)
    );

    ivc_prio u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_w),
        .mask_i (mask_q),
        .blk_i  (blk_q),
        .isr_i  (isr_q),
        .nest_i (ctl_q[CTL_NEST]),
        .hit_o  (hit_w),
        .rank_o (rank_w),
        .vec_o  (vec_w)
    );

    assign take_w = irq_ack & irq_req;

    // software-visible registers and the one-cycle blackout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctl_q  <= '0;
            blk_q  <= 1'b0;
        end else begin
            blk_q <= mask_we;
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
            if (ctl_we) begin
                ctl_q <= ctl_wdata;
            end
        end
    end

    // in-service set: release the highest-priority level, then record a take
    always_comb begin
        logic cleared;
        cleared = 1'b0;
        isr_d   = isr_q;
        if (irq_rti) begin
            for (int i = 0; i < NSRC; i++) begin
                if (!cleared && isr_q[i]) begin
                    isr_d[i] = 1'b0;
                    cleared  = 1'b1;
                end
            end
        end
        if (take_w) begin
            isr_d[rank_w] = 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_w) state_d = ST_SERVE;
            ST_SERVE: if (isr_d == '0) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            isr_q   <= '0;
        end else begin
            state_q <= state_d;
            isr_q   <= isr_d;
        end
    end

    // outputs
    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        unique case (state_q)
            ST_IDLE: begin
                irq_req = hit_w;
                irq_vec = hit_w ? vec_w : '0;
            end
            ST_SERVE: begin
                irq_req = hit_w & ctl_q[CTL_NEST];
                irq_vec = (hit_w & ctl_q[CTL_NEST]) ? vec_w : '0;
            end
        endcase
    end

    AST_BLACKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (!irq_req || rank_w < IDX_W'(2))); // R3
    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[CTL_NEST] && isr_q != '0) |-> !irq_req); // R9
    AST_NEST_OUTRANK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && isr_q != '0) |->
        ((isr_q & ((NSRC'(1) << (32'(rank_w) + 1)) - NSRC'(1))) == '0)); // R8
    AST_TAKE_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
        take_w |=> (state_q == ST_SERVE)); // R7
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (isr_q == '0)); // R11
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ext_n = 6'h3F;
    logic        boot_req = 0, pdn_req = 0, sp0_tx_req = 0, sp0_rx_req = 0;
    logic        dma_req = 0, sp1_tx_req = 0, sp1_rx_req = 0, tmr_req = 0;
    logic        mask_we = 0, ctl_we = 0, fc_we = 0, irq_ack = 0, irq_rti = 0;
    logic [9:0]  mask_wdata = '0;
    logic [4:0]  ctl_wdata = '0;
    logic [19:0] fc_wdata = '0;
    logic        irq_req;
    logic [15:0] irq_vec;

    int    nchk = 0;
    int    nerr = 0;
    string tag = "R11";

    always #2.5 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .boot_req(boot_req), .pdn_req(pdn_req),
        .sp0_tx_req(sp0_tx_req), .sp0_rx_req(sp0_rx_req), .dma_req(dma_req),
        .sp1_tx_req(sp1_tx_req), .sp1_rx_req(sp1_rx_req), .tmr_req(tmr_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .fc_we(fc_we), .fc_wdata(fc_wdata), .irq_ack(irq_ack), .irq_rti(irq_rti),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // ---------------- behavioural reference model ----------------
    bit       m_s1[6], m_s2[6], m_prev[6];
    bit       m_lat[12];
    bit [9:0] m_mask;
    bit [4:0] m_ctl;
    bit       m_blk;
    bit [11:0] m_isr;

    function automatic bit [11:0] m_requests();
        bit [11:0] r;
        bit lv[6];
        for (int k = 0; k < 6; k++) lv[k] = !m_s2[k];
        r = '0;
        r[0]  = boot_req;
        r[1]  = pdn_req;
        r[2]  = m_lat[2] | (!m_ctl[0] & lv[0]);
        r[3]  = m_lat[3] | lv[1];
        r[4]  = m_lat[4] | lv[2];
        r[5]  = m_lat[5] | sp0_tx_req;
        r[6]  = m_lat[6] | sp0_rx_req;
        r[7]  = m_lat[7];
        r[8]  = m_lat[8] | dma_req;
        if (m_ctl[4]) begin
            r[9]  = m_lat[9]  | (!m_ctl[1] & lv[4]);
            r[10] = m_lat[10] | (!m_ctl[2] & lv[5]);
        end else begin
            r[9]  = m_lat[9]  | sp1_tx_req;
            r[10] = m_lat[10] | sp1_rx_req;
        end
        r[11] = m_lat[11] | tmr_req;
        return r;
    endfunction

    // returns rank offered, or -1
    function automatic int m_offer();
        bit [11:0] r;
        int cand, low_svc;
        r = m_requests();
        cand = -1;
        for (int i = 11; i >= 0; i--)
            if (r[i] && (i < 2 || (m_mask[i-2] && !m_blk))) cand = i;
        low_svc = 99;
        for (int i = 11; i >= 0; i--) if (m_isr[i]) low_svc = i;
        if (cand < 0) return -1;
        if (low_svc == 99) return cand;
        if (m_ctl[3] && cand < low_svc) return cand;
        return -1;
    endfunction

    function automatic int m_vec(input int rank);
        if (rank <= 0) return 0;
        if (rank == 1) return 'h2C;
        return 4 * (rank - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) begin m_s1[k] = 1; m_s2[k] = 1; m_prev[k] = 1; end
            for (int i = 0; i < 12; i++) m_lat[i] = 0;
            m_mask = '0; m_ctl = '0; m_blk = 0; m_isr = '0;
        end else begin
            int  off;
            bit  take;
            bit  fall[6];
            bit  ev[12];
            off  = m_offer();
            take = irq_ack && (off >= 0);
            for (int k = 0; k < 6; k++) fall[k] = m_prev[k] && !m_s2[k];
            for (int i = 0; i < 12; i++) ev[i] = 0;
            ev[2]  = m_ctl[0] && fall[0];
            ev[7]  = fall[3];
            ev[9]  = m_ctl[4] && m_ctl[1] && fall[4];
            ev[10] = m_ctl[4] && m_ctl[2] && fall[5];
            for (int i = 2; i < 12; i++) begin
                bit st, cl;
                st = (fc_we && fc_wdata[i-2]) || ev[i];
                cl = (fc_we && fc_wdata[10+i-2]) || (take && off == i);
                m_lat[i] = (m_lat[i] && !cl) || st;
            end
            if (irq_rti) begin
                for (int i = 0; i < 12; i++)
                    if (m_isr[i]) begin m_isr[i] = 0; break; end
            end
            if (take) m_isr[off] = 1;
            m_blk = mask_we;
            if (mask_we) m_mask = mask_wdata;
            if (ctl_we) m_ctl = ctl_wdata;
            for (int k = 0; k < 6; k++) begin
                m_prev[k] = m_s2[k];
                m_s2[k]   = m_s1[k];
                m_s1[k]   = ext_n[k];
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        int off;
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            off = m_offer();
            check(irq_req == (off >= 0), tag, "model irq_req", irq_req, off >= 0);
            check(irq_vec == m_vec(off), tag, "model irq_vec", irq_vec, m_vec(off));
        end
    endtask

    task automatic expect_out(input string req, input bit r, input int v);
        check(irq_req == r, req, "irq_req", irq_req, r);
        check(irq_vec == v, req, "irq_vec", irq_vec, v);
    endtask

    task automatic wr_mask(input logic [9:0] v);
        mask_wdata = v; mask_we = 1; tick(); mask_we = 0;
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        ctl_wdata = v; ctl_we = 1; tick(); ctl_we = 0;
    endtask

    task automatic wr_fc(input logic [19:0] v);
        fc_wdata = v; fc_we = 1; tick(); fc_we = 0;
    endtask

    task automatic take_it();
        irq_ack = 1; tick(); irq_ack = 0;
    endtask

    task automatic ret();
        irq_rti = 1; tick(); irq_rti = 0;
    endtask

    task automatic cleanup();
        wr_fc(20'hFFC00);
        repeat (12) ret();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL ALL watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        tag = "R11";
        expect_out("R11", 0, 0);

        // R1: non-maskable ranks and their vectors
        tag = "R1";
        boot_req = 1; pdn_req = 1; tick();
        expect_out("R1", 1, 'h0000);
        boot_req = 0; tick();
        expect_out("R1", 1, 'h002C);
        take_it();
        tag = "R9";
        expect_out("R9", 0, 0);
        pdn_req = 0; ret(); tick();
        expect_out("R9", 0, 0);

        // R2 and R3
        tag = "R2";
        tmr_req = 1; tick();
        expect_out("R2", 0, 0);
        wr_mask(10'h3FF);
        expect_out("R3", 0, 0);
        tick();
        expect_out("R2", 1, 'h0028);
        sp0_rx_req = 1; dma_req = 1; tick();
        expect_out("R1", 1, 'h0014);
        tag = "R3";
        pdn_req = 1;
        wr_mask(10'h3EF);
        expect_out("R3", 1, 'h002C);
        pdn_req = 0;
        wr_mask(10'h3EF);
        expect_out("R3", 0, 0);
        tick();
        expect_out("R2", 1, 'h001C);
        tmr_req = 0; dma_req = 0; sp0_rx_req = 0; tick();
        wr_mask(10'h3FF); tick();

        // R4 level then edge on line 0
        tag = "R4";
        ext_n[0] = 0; tick();
        expect_out("R4", 0, 0);
        tick();
        expect_out("R4", 1, 'h0004);
        ext_n[0] = 1; tick(); tick();
        expect_out("R4", 0, 0);
        wr_ctl(5'b00001);
        ext_n[0] = 0; tick(); tick();
        expect_out("R4", 0, 0);
        tick();
        expect_out("R4", 1, 'h0004);
        ext_n[0] = 1; tick(); tick(); tick();
        expect_out("R4", 1, 'h0004);
        tag = "R7";
        take_it();
        ret();
        expect_out("R7", 0, 0);

        // R5 fixed-sense lines
        tag = "R5";
        ext_n[1] = 0; tick(); tick();
        expect_out("R5", 1, 'h0008);
        ext_n[1] = 1; tick(); tick();
        expect_out("R5", 0, 0);
        ext_n[3] = 0; tick(); tick(); tick();
        expect_out("R5", 1, 'h0018);
        ext_n[3] = 1; tick(); tick();
        expect_out("R5", 1, 'h0018);

        // R6 force and clear
        tag = "R6";
        wr_fc(20'h08000);
        expect_out("R6", 0, 0);
        wr_fc(20'h00200);
        expect_out("R6", 1, 'h0028);
        wr_fc(20'h80000);
        expect_out("R6", 0, 0);

        // R8 nested stack
        tag = "R8";
        wr_ctl(5'b01000);
        wr_fc(20'h00200);
        take_it();
        wr_fc(20'h00040);
        expect_out("R8", 1, 'h001C);
        take_it();
        wr_fc(20'h00200);
        expect_out("R8", 0, 0);
        ret();
        expect_out("R8", 0, 0);
        ret();
        expect_out("R8", 1, 'h0028);
        cleanup();

        // R9 sequential
        tag = "R9";
        wr_ctl(5'b00000);
        wr_fc(20'h00200);
        take_it();
        wr_fc(20'h00001);
        expect_out("R9", 0, 0);
        ret();
        expect_out("R9", 1, 'h0004);
        cleanup();

        // R10 serial-port-1 vectors reassigned to lines
        tag = "R10";
        wr_ctl(5'b10000);
        sp1_tx_req = 1; tick();
        expect_out("R10", 0, 0);
        ext_n[4] = 0; tick(); tick();
        expect_out("R10", 1, 'h0020);
        ext_n[4] = 1; tick(); tick();
        wr_ctl(5'b00000);
        expect_out("R10", 1, 'h0020);
        sp1_tx_req = 0; ext_n[5] = 0; tick(); tick();
        expect_out("R10", 0, 0);
        ext_n[5] = 1; tick(); tick();

        // randomized mix against the model
        tag = "R8";
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 7) == 0) ext_n[$urandom_range(0, 5)] ^= 1'b1;
            if ($urandom_range(0, 63) == 0) boot_req = ~boot_req;
            if ($urandom_range(0, 63) == 0) pdn_req = ~pdn_req;
            if ($urandom_range(0, 15) == 0) sp0_tx_req = ~sp0_tx_req;
            if ($urandom_range(0, 15) == 0) sp0_rx_req = ~sp0_rx_req;
            if ($urandom_range(0, 15) == 0) dma_req = ~dma_req;
            if ($urandom_range(0, 15) == 0) sp1_tx_req = ~sp1_tx_req;
            if ($urandom_range(0, 15) == 0) sp1_rx_req = ~sp1_rx_req;
            if ($urandom_range(0, 15) == 0) tmr_req = ~tmr_req;
            mask_we = ($urandom_range(0, 15) == 0);
            mask_wdata = 10'($urandom);
            ctl_we = ($urandom_range(0, 31) == 0);
            ctl_wdata = 5'($urandom);
            fc_we = ($urandom_range(0, 11) == 0);
            fc_wdata = 20'($urandom) & 20'($urandom) & 20'($urandom);
            irq_rti = ($urandom_range(0, 5) == 0);
            #1;
            irq_ack = irq_req && ($urandom_range(0, 1) == 1);
            tick();
        end
        mask_we = 0; ctl_we = 0; fc_we = 0; irq_rti = 0; irq_ack = 0;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule